// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns 8-bit characters into asynchronous serial frames on a single line. A write port with a one-bit register select loads either an 8-bit control register or a transmit holding register. The control register sets three things: the bit-clock divide ratio, one of eight fixed frame formats, and a handshake code. The handshake code drives a request-to-send output, gates a transmit interrupt, or forces a break on the line.

A character written to the holding register moves into the shifter as soon as the shifter is free. The holding-empty flag then rises, so the next character can be written while the current one is shifting out. Divider code 11 acts as a master reset. It aborts any frame in progress, marks the holding register empty and ignores data writes while it stays selected. After reset the control register is 8'h03, so the block stays in master reset until software configures it.

Top module: `ser_xmit`

## Requirements
- R1: After rst_n, txd is 1, hold_empty is 1, rts is 0 and tx_irq is 0. The control register resets to 8'h03, which selects master reset.
- R2: Control bits [1:0] set the bit period: 00 gives 1 clock per bit, 01 gives 16 and 10 gives 64.
- R3: A frame is sent in this order: a 0 start bit, the data bits LSB first, the parity bit when enabled, then stop bits of 1. Between frames the line idles at 1.
- R4: Control bits [4:2] from 000 to 011 select 7 data bits (bit 7 of the character is not sent). 000 and 001 add 2 stop bits, 010 and 011 add 1 stop bit. Codes 000 and 010 use even parity; codes 001 and 011 use odd parity.
- R5: Control bits [4:2] from 100 to 111 select 8 data bits: 100 gives 2 stop bits and no parity, 101 gives 1 stop bit and no parity, 110 gives 1 stop bit with even parity, 111 gives 1 stop bit with odd parity.
- R6: With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity they hold an odd number.
- R7: A write with wr_sel=1 loads the holding register and clears hold_empty at that edge. A write with wr_sel=0 loads the control register. hold_empty rises again when the character enters the shifter.
- R8: A character waiting in the holding register starts its start bit directly after the last stop bit of the current frame, with no idle time between them.
- R9: rts is 1 only when control bits [6:5] are 10.
- R10: tx_irq equals hold_empty AND (control bits [6:5] equal 01).
- R11: While control bits [6:5] are 11, txd is held at 0. When the code changes and no frame is active, the line returns to 1.
- R12: While control bits [1:0] are 11, any frame in progress is aborted (txd returns to 1), hold_empty is 1 and data writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the holding register |
| wr_data | input | 8 | Write data |
| txd | output | 1 | Serial line output |
| rts | output | 1 | Request-to-send output |
| tx_irq | output | 1 | Transmit interrupt request |
| hold_empty | output | 1 | Holding register can accept a character |

## Verification
A corrupted bit counter or shifter shows up on txd within the frame it affects: a wrong bit value, a frame that is too short or too long, or a late start. The scoreboard checks every bit in the middle of its bit period and measures when each start bit begins relative to the previous one. A stuck holding-empty flag shows up one clock after a data write, through hold_empty and through tx_irq. A master reset that fails to abort leaves txd low or hold_empty clear on the second clock after the control write.

// File: rtl/ser_xmit.sv
module ser_xmit #(
  parameter int FW = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       rts,
  output logic       tx_irq,
  output logic       hold_empty
);
  localparam int CW = $clog2(FW + 1);

  logic [7:0]    ctrl, hold;
  logic          empty;
  logic [FW-1:0] sh, frm;
  logic [CW-1:0] cnt, len;
  logic [5:0]    pc, div_m1;

  wire [2:0] ws    = ctrl[4:2];
  wire [1:0] hs    = ctrl[6:5];
  wire mrst        = ctrl[1:0] == 2'b11;
  wire busy        = cnt != '0;
  wire tick        = pc == div_m1;
  wire last        = busy && tick && cnt == CW'(1);
  wire load        = !empty && !mrst && (!busy || last);
  wire par_en      = !(ws[2] && !ws[1]);
  wire two_stop    = !ws[1] && !(ws[2] && ws[0]);
  wire par_bit     = (ws[2] ? ^hold : ^hold[6:0]) ^ ws[0];

  assign div_m1 = (ctrl[1:0] == 2'b00) ? 6'd0 : (ctrl[1:0] == 2'b01) ? 6'd15 : 6'd63;
  assign len    = CW'(1) + (ws[2] ? CW'(8) : CW'(7)) + CW'(par_en) + (two_stop ? CW'(2) : CW'(1));

  always_comb begin
    frm      = '1;
    frm[0]   = 1'b0;
    frm[7:1] = hold[6:0];
    if (ws[2]) begin
      frm[8] = hold[7];
      if (par_en) frm[9] = par_bit;
    end else begin
      frm[8] = par_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= 8'h03;
      hold  <= '0;
      empty <= 1'b1;
      sh    <= '1;
      cnt   <= '0;
      pc    <= '0;
    end else begin
      if (wr_en && !wr_sel) ctrl <= wr_data;
      if (mrst) begin
        empty <= 1'b1;
        cnt   <= '0;
        pc    <= '0;
        sh    <= '1;
      end else begin
        if (load) begin
          sh    <= frm;
          cnt   <= len;
          pc    <= '0;
          empty <= 1'b1;
        end else if (busy) begin
          if (tick) begin
            pc  <= '0;
            sh  <= {1'b1, sh[FW-1:1]};
            cnt <= cnt - CW'(1);
          end else begin
            pc <= pc + 6'd1;
          end
        end
        if (wr_en && wr_sel) begin
          hold  <= wr_data;
          empty <= 1'b0;
        end
      end
    end
  end

  assign txd        = (hs == 2'b11) ? 1'b0 : (busy ? sh[0] : 1'b1);
  assign rts        = hs == 2'b10;
  assign tx_irq     = empty && hs == 2'b01;
  assign hold_empty = empty;
endmodule

module ser_xmit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] ctrl,
  input logic       busy,
  input logic       txd,
  input logic       tx_irq,
  input logic       hold_empty
);
  assert_irq_needs_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_empty |-> !tx_irq);
  assert_break_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[6:5] == 2'b11 |-> !txd);
  assert_mrst_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[1:0] == 2'b11 |=> hold_empty && !busy);
  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrl[6:5] != 2'b11) |-> txd);
  assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && ctrl[1:0] != 2'b11) |=> !hold_empty);
endmodule

bind ser_xmit ser_xmit_chk u_chk (.*);

// File: tb/ser_xmit_bench.sv
module ser_xmit_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic txd, rts, tx_irq, hold_empty;
  int checks = 0, errors = 0;
  int cur_div = 1;
  logic [2:0] cur_ws = 0;
  logic [11:0] q_bits[$];
  int q_len[$];
  bit q_gap[$];
  bit mon_busy = 0;

  ser_xmit u_ser_xmit (.*);

  always #2 clk = ~clk;

  task automatic chk(input string r, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cfg(input logic [1:0] hs, input logic [2:0] ws, input logic [1:0] dv);
    wr(0, {1'b0, hs, ws, dv});
    cur_ws = ws;
    cur_div = (dv == 2'b00) ? 1 : (dv == 2'b01) ? 16 : 64;
  endtask

  task automatic send(input logic [7:0] d, input bit gap);
    logic [11:0] b; int nd, idx, ones; bit s2, pen;
    while (!hold_empty) @(negedge clk);
    nd = cur_ws[2] ? 8 : 7;
    s2 = (cur_ws == 3'd0 || cur_ws == 3'd1 || cur_ws == 3'd4);
    pen = !(cur_ws == 3'd4 || cur_ws == 3'd5);
    b = '1; b[0] = 0; ones = 0;
    for (int i = 0; i < nd; i++) begin b[1+i] = d[i]; ones += d[i]; end
    idx = 1 + nd;
    if (pen) begin b[idx] = cur_ws[0] ? ~ones[0] : ones[0]; idx++; end
    q_bits.push_back(b); q_len.push_back(idx + (s2 ? 2 : 1)); q_gap.push_back(gap);
    wr(1, d);
  endtask

  task automatic drain();
    while (q_bits.size() != 0 || mon_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: every frame bit (R2 R3 R4 R5 R6) and back-to-back start timing (R8)
  initial begin
    time prev_t = 0; int prev_n = 0, prev_div = 1;
    forever begin
      logic [11:0] b, got; int n; bit g;
      @(negedge clk);
      if (q_bits.size() != 0 && txd == 0) begin
        mon_busy = 1;
        b = q_bits.pop_front(); n = q_len.pop_front(); g = q_gap.pop_front();
        if (g) chk("R8 start time", int'(($time - prev_t) / 4), prev_n * prev_div);
        prev_t = $time; prev_n = n; prev_div = cur_div;
        got = '1;
        repeat (cur_div / 2) @(negedge clk);
        got[0] = txd;
        for (int k = 1; k < n; k++) begin
          repeat (cur_div) @(negedge clk);
          got[k] = txd;
        end
        chk("R2 R3 R4 R5 R6 frame", int'(got), int'(b));
        mon_busy = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 txd", txd, 1); chk("R1 empty", hold_empty, 1);
    chk("R1 rts", rts, 0); chk("R1 irq", tx_irq, 0);
    wr(1, 8'h5A); @(negedge clk);
    chk("R1 R12 write ignored in reset state", hold_empty, 1);
    chk("R1 R12 line idle", txd, 1);

    for (int w = 0; w < 8; w++) begin
      cfg(2'b00, 3'(w), 2'b00);
      send(8'hA5 ^ 8'(w * 37), 0);
      drain();
    end
    cfg(2'b00, 3'd3, 2'b01); send(8'h81, 0); drain();
    cfg(2'b00, 3'd6, 2'b01); send(8'h3C, 0); send(8'hC7, 1); drain();
    cfg(2'b00, 3'd0, 2'b10); send(8'h7E, 0); drain();

    cfg(2'b10, 3'd5, 2'b00); @(negedge clk);
    chk("R9 rts code 10", rts, 1); chk("R10 irq off code 10", tx_irq, 0);
    cfg(2'b00, 3'd5, 2'b00); @(negedge clk);
    chk("R9 rts code 00", rts, 0);

    cfg(2'b01, 3'd5, 2'b10); @(negedge clk);
    chk("R10 irq when empty", tx_irq, 1);
    send(8'h11, 0);
    send(8'h22, 1);
    chk("R7 empty cleared", hold_empty, 0);
    chk("R10 irq low when full", tx_irq, 0);
    drain();
    chk("R7 empty after load", hold_empty, 1);
    chk("R10 irq back", tx_irq, 1);

    cfg(2'b11, 3'd5, 2'b00); repeat (5) @(negedge clk);
    chk("R11 break low", txd, 0); chk("R9 rts in break", rts, 0);
    chk("R10 irq off in break", tx_irq, 0);
    cfg(2'b00, 3'd5, 2'b00); @(negedge clk);
    chk("R11 line back to idle", txd, 1);

    cfg(2'b00, 3'd5, 2'b10);
    wr(1, 8'h00); repeat (100) @(negedge clk);
    chk("R12 frame running", txd, 0);
    wr(0, 8'h17); @(negedge clk);
    chk("R12 abort txd", txd, 1); chk("R12 abort empty", hold_empty, 1);
    wr(1, 8'h00); repeat (3) @(negedge clk);
    chk("R12 data write ignored", hold_empty, 1);
    cfg(2'b00, 3'd5, 2'b00); repeat (4) @(negedge clk);
    chk("R12 no frame after release", txd, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule